// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block keeps the control state for a small set of hardware breakpoint and watchpoint triggers beside a processor core. Software reaches it through the core's control-register port: one register chooses which trigger is being looked at, a control word and a compare value belong to each trigger, and a third per-trigger word is wired to zero. The block does not compare anything against bus traffic and does not enter debug mode. It holds the settings and exports summary enables. The fetch, load and store paths use these enables to see whether any trigger asks for their kind of check.

A trigger can be claimed for the debugger with an ownership bit in its control word. Once that bit is set, only code running in debug mode can change that trigger's control word or compare value. Writes from other modes are dropped without any trace. When a trigger is armed to match on instruction execution, its timing field is cleared, so execute matches always fire before the instruction. The read layout follows a width input. In 32-bit mode the constant fields move down into bits 31..21 and bits 63..32 read as zero.

Top module: `trig_bank`

## Requirements
- R1: After reset the select register reads 0. Every trigger's control word reads with the value 2 in its top four bits and zero everywhere else. Every compare value reads 0.
- R2: A write to the select register (address 0x7A0) is accepted only when the written value is below NUM_TRIG. Otherwise the select register keeps its previous value.
- R3: The control word (address 0x7A1) places these fields: select at bit 19, timing at 18, action at 17..12, chain at 11, match at 10..7, execute at 2, store at 1 and load at 0. These fields read back as written. All other low bits read 0.
- R4: Any control-word write that leaves the execute bit at 1 stores the timing bit as 0.
- R5: While the selected trigger's ownership bit is 1 and dbg_mode is 0, writes to its control word and compare value have no effect. With dbg_mode at 1 the same writes are accepted.
- R6: The ownership bit (bit 59, or bit 27 in 32-bit mode) is loaded from the write data on every accepted control-word write. It can therefore be set from any mode and cleared only under the rule of R5.
- R7: The type field (value 2) and the mask-max field (bits 58..53, or 26..21 in 32-bit mode, value MASKMAX) ignore written data. The third data word (0x7A3) and any unknown address read 0.
- R8: fetch_chk_en is 1 exactly when at least one trigger has execute set, whatever its action field holds. load_chk_en and store_chk_en follow the load and store bits in the same way.
- R9: With xlen_narrow at 1, reads carry zeros in bits 63..32, the type field sits at bits 31..28, and compare-value writes store only bits 31..0, zero-extended.
- R10: Each trigger holds its own compare value at address 0x7A2. Reads return the value of the trigger chosen by the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | Register address, used for both read and write |
| csr_wdata | input | 64 | Write data |
| csr_we | input | 1 | Write strobe, sampled on the rising edge |
| csr_rdata | output | 64 | Combinational read data for csr_addr |
| dbg_mode | input | 1 | Core is currently in debug mode |
| xlen_narrow | input | 1 | 1 selects the 32-bit register layout |
| fetch_chk_en | output | 1 | Some trigger is armed for execution |
| load_chk_en | output | 1 | Some trigger is armed for loads |
| store_chk_en | output | 1 | Some trigger is armed for stores |

## Verification
The bench builds the bank with NUM_TRIG = 3, which is not a power of two. The select register is then two bits wide, and the value 3 fits in it but must still be refused, so the bench can reach the case of an encodable but unimplemented index. MASKMAX stays at 0, so the bench can show that written ones in that field never stick. It also runs the same triggers under both layout widths, which moves the ownership bit and the type field, and it checks the aggregate enables against triggers whose action fields differ.

// File: rtl/trig_bank_pkg.sv
package trig_bank_pkg;

  localparam int unsigned WORD_W = 64;

  localparam logic [11:0] ADDR_SEL = 12'h7A0;
  localparam logic [11:0] ADDR_TD1 = 12'h7A1;
  localparam logic [11:0] ADDR_TD2 = 12'h7A2;
  localparam logic [11:0] ADDR_TD3 = 12'h7A3;

  localparam logic [3:0] TYPE_ADDR_DATA = 4'd2;

  typedef struct packed {
    logic       owned;
    logic       sel;
    logic       timing;
    logic [5:0] action;
    logic       chain;
    logic [3:0] match;
    logic       execute;
    logic       store;
    logic       load;
  } trig_ctl_t;

  // Fold a write word to the active width.
  function automatic logic [WORD_W-1:0] fold_width(input logic [WORD_W-1:0] w,
                                                   input logic narrow);
    return narrow ? {32'b0, w[31:0]} : w;
  endfunction

  // Pull the writable fields out of a written word; execute clears timing.
  function automatic trig_ctl_t ctl_from_word(input logic [WORD_W-1:0] w,
                                              input logic narrow);
    trig_ctl_t c;
    c.owned   = narrow ? w[27] : w[59];
    c.sel     = w[19];
    c.timing  = w[18] & ~w[2];
    c.action  = w[17:12];
    c.chain   = w[11];
    c.match   = w[10:7];
    c.execute = w[2];
    c.store   = w[1];
    c.load    = w[0];
    return c;
  endfunction

  // Lay a control record out as a read word for the active width.
  function automatic logic [WORD_W-1:0] ctl_to_word(input trig_ctl_t c,
                                                    input logic narrow,
                                                    input logic [5:0] maskmax);
    logic [WORD_W-1:0] w;
    w = '0;
    w[19]    = c.sel;
    w[18]    = c.timing;
    w[17:12] = c.action;
    w[11]    = c.chain;
    w[10:7]  = c.match;
    w[2]     = c.execute;
    w[1]     = c.store;
    w[0]     = c.load;
    if (narrow) begin
      w[31:28] = TYPE_ADDR_DATA;
      w[27]    = c.owned;
      w[26:21] = maskmax;
    end else begin
      w[63:60] = TYPE_ADDR_DATA;
      w[59]    = c.owned;
      w[58:53] = maskmax;
    end
    return w;
  endfunction

endpackage

// File: rtl/trig_slot.sv
module trig_slot
  import trig_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  trig_ctl_t         ctl_nxt,
  input  logic              cmp_wr,
  input  logic [WORD_W-1:0] cmp_nxt,
  output trig_ctl_t         ctl_q,
  output logic [WORD_W-1:0] cmp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_nxt;
      if (cmp_wr) cmp_q <= cmp_nxt;
    end
  end

endmodule

// File: rtl/trig_rd_mux.sv
module trig_rd_mux
  import trig_bank_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned SEL_W    = 2,
  parameter logic [5:0]  MASKMAX  = 6'd0
) (
  input  logic [11:0]       addr,
  input  logic              narrow,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic              sel_valid,
  input  trig_ctl_t         sel_ctl,
  input  logic [WORD_W-1:0] sel_cmp,
  output logic [WORD_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_SEL: rdata = {{(WORD_W-SEL_W){1'b0}}, sel_q};
      ADDR_TD1: if (sel_valid) rdata = ctl_to_word(sel_ctl, narrow, MASKMAX);
      ADDR_TD2: if (sel_valid) rdata = fold_width(sel_cmp, narrow);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_bank_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  parameter logic [5:0]  MASKMAX  = 6'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  input  logic              csr_we,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              dbg_mode,
  input  logic              xlen_narrow,
  output logic              fetch_chk_en,
  output logic              load_chk_en,
  output logic              store_chk_en
);

  localparam int unsigned SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] wval;
  logic              sel_wr_ok;
  logic              sel_valid;
  trig_ctl_t         sel_ctl;
  logic [WORD_W-1:0] sel_cmp;
  logic              wr_locked;
  trig_ctl_t         ctl_nxt;

  // Named event and state wires for the checker.
  trig_ctl_t         ctl_q   [NUM_TRIG];
  logic [WORD_W-1:0] cmp_q   [NUM_TRIG];
  logic [NUM_TRIG-1:0] owned_vec;
  logic [NUM_TRIG-1:0] exec_vec;
  logic [NUM_TRIG-1:0] load_vec;
  logic [NUM_TRIG-1:0] store_vec;

  assign wval      = fold_width(csr_wdata, xlen_narrow);
  assign sel_wr_ok = csr_we && (csr_addr == ADDR_SEL) && (wval < WORD_W'(NUM_TRIG));
  assign ctl_nxt   = ctl_from_word(wval, xlen_narrow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (sel_wr_ok) sel_q <= wval[SEL_W-1:0];
  end

  assign sel_valid = (32'(sel_q) < NUM_TRIG);

  always_comb begin
    sel_ctl = '0;
    sel_cmp = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (32'(sel_q) == i) begin
        sel_ctl = ctl_q[i];
        sel_cmp = cmp_q[i];
      end
    end
  end

  assign wr_locked = sel_ctl.owned && !dbg_mode;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    logic hit;
    assign hit = (32'(sel_q) == g) && csr_we && !wr_locked;

    trig_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (hit && (csr_addr == ADDR_TD1)),
      .ctl_nxt (ctl_nxt),
      .cmp_wr  (hit && (csr_addr == ADDR_TD2)),
      .cmp_nxt (wval),
      .ctl_q   (ctl_q[g]),
      .cmp_q   (cmp_q[g])
    );

    assign owned_vec[g] = ctl_q[g].owned;
    assign exec_vec[g]  = ctl_q[g].execute;
    assign load_vec[g]  = ctl_q[g].load;
    assign store_vec[g] = ctl_q[g].store;
  end

  assign fetch_chk_en = |exec_vec;
  assign load_chk_en  = |load_vec;
  assign store_chk_en = |store_vec;

  trig_rd_mux #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (SEL_W),
    .MASKMAX  (MASKMAX)
  ) u_rd (
    .addr      (csr_addr),
    .narrow    (xlen_narrow),
    .sel_q     (sel_q),
    .sel_valid (sel_valid),
    .sel_ctl   (sel_ctl),
    .sel_cmp   (sel_cmp),
    .rdata     (csr_rdata)
  );

endmodule

// File: rtl/trig_bank_chk.sv
module trig_bank_chk
  import trig_bank_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned SEL_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [11:0]         csr_addr,
  input logic [WORD_W-1:0]   csr_wdata,
  input logic                csr_we,
  input logic [WORD_W-1:0]   csr_rdata,
  input logic                dbg_mode,
  input logic                xlen_narrow,
  input logic                fetch_chk_en,
  input logic [SEL_W-1:0]    sel_q,
  input logic [NUM_TRIG-1:0] owned_vec,
  input logic [NUM_TRIG-1:0] exec_vec
);

  logic [WORD_W-1:0] w_eff;
  logic              lock_now;
  assign w_eff    = xlen_narrow ? {32'b0, csr_wdata[31:0]} : csr_wdata;
  assign lock_now = ((owned_vec >> sel_q) & NUM_TRIG'(1)) != '0;

  p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM_TRIG);

  p_sel_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == ADDR_SEL && w_eff >= WORD_W'(NUM_TRIG)) |=> $stable(sel_q));

  p_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_TD1 && !xlen_narrow) |-> csr_rdata[63:60] == TYPE_ADDR_DATA);

  p_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_TD1 && csr_rdata[2]) |-> !csr_rdata[18]);

  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (csr_addr == ADDR_TD1 || csr_addr == ADDR_TD2) && !dbg_mode && lock_now)
      |=> ($stable(owned_vec) && $stable(exec_vec)));

  p_td3_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_TD3) |-> csr_rdata == '0);

  p_fetch_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_chk_en) |-> $past(csr_we));

  p_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xlen_narrow |-> csr_rdata[63:32] == 32'b0);

endmodule

bind trig_bank trig_bank_chk #(
  .NUM_TRIG (NUM_TRIG),
  .SEL_W    (SEL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_addr     (csr_addr),
  .csr_wdata    (csr_wdata),
  .csr_we       (csr_we),
  .csr_rdata    (csr_rdata),
  .dbg_mode     (dbg_mode),
  .xlen_narrow  (xlen_narrow),
  .fetch_chk_en (fetch_chk_en),
  .sel_q        (sel_q),
  .owned_vec    (owned_vec),
  .exec_vec     (exec_vec)
);

// File: tb/trig_bank_tb.sv
module trig_bank_tb;

  localparam int NT = 3;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic        csr_we = 1'b0;
  logic [63:0] csr_rdata;
  logic        dbg_mode = 1'b0;
  logic        xlen_narrow = 1'b0;
  logic        fetch_chk_en, load_chk_en, store_chk_en;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  trig_bank #(.NUM_TRIG(NT), .MASKMAX(6'd0)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .dbg_mode(dbg_mode),
    .xlen_narrow(xlen_narrow), .fetch_chk_en(fetch_chk_en),
    .load_chk_en(load_chk_en), .store_chk_en(store_chk_en)
  );

  // Vector table: write strobe, address, data, debug flag, expected read-back.
  localparam logic        T_WE  [NV] = '{1,1,1,1,1,1,1,0,1,1,1,1,1,1};
  localparam logic [11:0] T_AD  [NV] = '{12'h7A0,12'h7A0,12'h7A0,12'h7A1,12'h7A1,12'h7A2,12'h7A0,
                                         12'h7A2,12'h7A3,12'h7A1,12'h7A1,12'h7A2,12'h7A1,12'h300};
  localparam logic [63:0] T_WD  [NV] = '{64'h1, 64'h3, 64'h2,
                                         64'hF7E0_0000_000C_5983,  // R3 R7 all fields, ro ones
                                         64'h0000_0000_000C_0004,  // R4 execute with timing
                                         64'hDEAD_BEEF_1234_5678,  // R10
                                         64'h0, 64'h0,
                                         64'hFFFF,                 // R7 third word
                                         64'h0800_0000_0000_0001,  // R6 claim outside debug
                                         64'h2, 64'h55,            // R5 locked
                                         64'h2,                    // R5 R6 debug clears claim
                                         64'h1234};
  localparam logic        T_DBG [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,0};
  localparam logic [63:0] T_EXP [NV] = '{64'h1, 64'h1, 64'h2,
                                         64'h2000_0000_000C_5983,
                                         64'h2000_0000_0008_0004,
                                         64'hDEAD_BEEF_1234_5678,
                                         64'h0, 64'h0, 64'h0,
                                         64'h2800_0000_0000_0001,
                                         64'h2800_0000_0000_0001,
                                         64'h0,
                                         64'h2000_0000_0000_0002,
                                         64'h0};
  localparam logic [23:0] T_REQ [NV] = '{"R2 ","R2 ","R2 ","R3 ","R4 ","R10","R2 ",
                                         "R10","R7 ","R6 ","R5 ","R5 ","R5 ","R7 "};

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write at one falling edge, read the same address one cycle later.
  task automatic wr_rd(input logic we, input logic [11:0] ad, input logic [63:0] wd,
                       input logic dbg);
    @(negedge clk);
    csr_we = we; csr_addr = ad; csr_wdata = wd; dbg_mode = dbg;
    @(negedge clk);
    csr_we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] ad);
    @(negedge clk);
    csr_we = 1'b0; csr_addr = ad;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h7A0); check64("R1 select", csr_rdata, 64'h0);
    rd(12'h7A1); check64("R1 ctl", csr_rdata, 64'h2000_0000_0000_0000);
    rd(12'h7A2); check64("R1 cmp", csr_rdata, 64'h0);
    check64("R8 reset enables", {61'b0, fetch_chk_en, load_chk_en, store_chk_en}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      wr_rd(T_WE[k], T_AD[k], T_WD[k], T_DBG[k]);
      check64($sformatf("%s vec%0d", T_REQ[k], k), csr_rdata, T_EXP[k]);
    end

    // R8: slot 2 has execute set; slot 0 has store set.
    check64("R8 fetch/load/store", {61'b0, fetch_chk_en, load_chk_en, store_chk_en}, 64'h5);
    wr_rd(1, 12'h7A0, 64'h2, 0);
    wr_rd(1, 12'h7A1, 64'h0000_0000_0003_F000, 0);  // execute clear, action nonzero
    check64("R8 fetch off", {63'b0, fetch_chk_en}, 64'h0);
    wr_rd(1, 12'h7A1, 64'h4, 0);                    // execute set, action zero
    check64("R8 fetch on", {63'b0, fetch_chk_en}, 64'h1);

    // R9 narrow layout
    xlen_narrow = 1'b1;
    rd(12'h7A1); check64("R9 narrow ctl", csr_rdata, 64'h2000_0004);
    wr_rd(1, 12'h7A2, 64'hAAAA_BBBB_CCCC_DDDD, 0);
    check64("R9 narrow cmp", csr_rdata, 64'hCCCC_DDDD);
    wr_rd(1, 12'h7A0, 64'h1_0000_0001, 0);           // upper bits dropped -> 1
    check64("R9 narrow select", csr_rdata, 64'h1);
    wr_rd(1, 12'h7A1, 64'h0800_0000, 0);
    check64("R6 narrow claim", csr_rdata, 64'h2800_0000);
    xlen_narrow = 1'b0;
    rd(12'h7A1); check64("R6 wide view of claim", csr_rdata, 64'h2800_0000_0000_0000);
    wr_rd(1, 12'h7A0, 64'h2, 0);
    rd(12'h7A2); check64("R9 cmp stored low only", csr_rdata, 64'hCCCC_DDDD);

    // R1 again after a second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(12'h7A0); check64("R1 select after reset", csr_rdata, 64'h0);
    check64("R1 enables after reset", {61'b0, fetch_chk_en, load_chk_en, store_chk_en}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule